// File: doc/BRIEF.md
# Peripheral Clock Enable Sequencer

This block brings one peripheral's clock and reset into a safe running state on request. An enable request on a peripheral that is already running finishes at once and touches nothing. Otherwise the block holds the peripheral in reset, waits a short interval, ungates the clock, waits a longer settle interval and then lets go of the reset. A peripheral with no reset line only has its clock ungated. A disable request only stops the clock. The block leaves the reset line alone.

The surrounding register bank owns the gate and reset state. This block reads that state on two inputs and asks for changes through one-cycle command pulses. It handles one request at a time. A request waits on a valid/ready handshake until the running sequence has completed, and the block raises `done` for one cycle when it finishes. Both waits are given in microseconds and turned into whole clock cycles, rounding up, from a clock-frequency parameter.

Top module: `clk_rst_seq`

## Requirements
- R1: After reset, and at any time reset is applied in the middle of a sequence, the block is idle: `req_ready`=1, `busy`=0, and every command pulse and `done` are 0.
- R2: The block treats a peripheral as running when `gate_running`=1 and it is not held in reset. "Held in reset" means `has_reset_line`=1 and `periph_in_reset`=1. An enable request (`req_enable`=1) on a running peripheral issues no command pulse and raises `done` in the first cycle after the accepting edge.
- R3: An enable request on a peripheral with a reset line that is not running produces the following sequence, counting cycle 0 as the first cycle after the accepting edge:
  - `rst_assert` in cycle 0.
  - `gate_on` in cycle PRE+1.
  - `rst_release` in cycle PRE+SETTLE+2.
  - `done` in cycle PRE+SETTLE+3.

  PRE is ceil(CLK_HZ·PRE_US/10^6) and SETTLE is ceil(CLK_HZ·SETTLE_US/10^6). Each is at least 1.
- R4: A peripheral held in reset counts as not running even when `gate_running`=1. An enable request on it runs the full sequence of R3.
- R5: An enable request on a peripheral without a reset line (`has_reset_line`=0) that has its clock stopped raises `gate_on` in cycle 0 and `done` in cycle 1. It raises no reset pulse, whatever `periph_in_reset` says.
- R6: A disable request (`req_enable`=0) raises `gate_off` in cycle 0 and `done` in cycle 1. It raises no reset pulse and no `gate_on`, whatever the gate and reset state are.
- R7: The block takes a request only when `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the accepting edge through the `done` cycle. A request that is withdrawn before `req_ready` returns has no effect. A request held valid is taken in the first cycle `req_ready` is 1 again.
- R8: Each command pulse and `done` lasts exactly one cycle. At most one of them is high in any cycle, and none is high while idle.
- R9: The block samples the gate and reset state and `has_reset_line` only at the accepting edge. Changes to them during a sequence do not alter that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_enable | input | 1 | 1 = enable request, 0 = disable request |
| req_ready | output | 1 | Block can take a request this cycle |
| gate_running | input | 1 | Current clock gate state, 1 = clock running |
| periph_in_reset | input | 1 | Current reset state, 1 = peripheral held in reset |
| has_reset_line | input | 1 | 1 = peripheral has a controllable reset |
| gate_on | output | 1 | One-cycle command: ungate the clock |
| gate_off | output | 1 | One-cycle command: gate the clock |
| rst_assert | output | 1 | One-cycle command: put the peripheral in reset |
| rst_release | output | 1 | One-cycle command: take the peripheral out of reset |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse: the sequence has finished |

## Verification
A fault in the state register or the wait counter appears at the ports as a command pulse moved away from its cycle. It can also appear as a missing pulse, or as a reset release with no reset assert before it. The bench compares every cycle of each sequence against a pulse schedule it computes itself, so a shift of one cycle shows up in the cycle where it happens. A request that was classified wrongly shows up in cycle 0, because that cycle already carries `rst_assert`, `gate_on`, `gate_off` or `done` depending on the decision. A handshake that takes a withdrawn request shows up as an extra `gate_off` within two cycles of `req_ready` returning.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_ON,
    ST_WAIT_PRE,
    ST_CLK_ON,
    ST_WAIT_SETTLE,
    ST_RST_OFF,
    ST_CLK_OFF,
    ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_NOP,
    OP_FULL,
    OP_CLK_ONLY,
    OP_GATE_OFF
  } seq_op_t;

  // whole cycles covering a wait given in microseconds, never below one
  function automatic int unsigned us_to_cycles(input longint unsigned hz,
                                               input longint unsigned us);
    longint unsigned c;
    c = (hz * us + 64'd999_999) / 64'd1_000_000;
    if (c == 64'd0) c = 64'd1;
    return c[31:0];
  endfunction

  // counter width able to hold values up to v-1
  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction

  // a peripheral held in reset never counts as running
  function automatic seq_op_t classify(input logic en, input logic gate_run,
                                       input logic in_rst, input logic has_rst);
    logic running;
    running = gate_run && !(has_rst && in_rst);
    if (!en)          return OP_GATE_OFF;
    else if (running) return OP_NOP;
    else if (has_rst) return OP_FULL;
    else              return OP_CLK_ONLY;
  endfunction

endpackage

// File: rtl/clkseq_decode.sv
module clkseq_decode
  import clkseq_pkg::*;
(
  input  logic    req_enable,
  input  logic    gate_running,
  input  logic    periph_in_reset,
  input  logic    has_reset_line,
  output seq_op_t op
);

  always_comb begin
    op = classify(req_enable, gate_running, periph_in_reset, has_reset_line);
  end

endmodule

// File: rtl/clkseq_timer.sv
module clkseq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/clkseq_fsm.sv
module clkseq_fsm
  import clkseq_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned PRE_CYC    = 1,
  parameter int unsigned SETTLE_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  seq_op_t          op,
  input  logic             timer_zero,
  output seq_state_t       state,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  localparam logic [CNT_W-1:0] PRE_LD    = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);

  seq_state_t state_q, state_d;
  logic       full_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          case (op)
            OP_NOP:      state_d = ST_DONE;
            OP_FULL:     state_d = ST_RST_ON;
            OP_CLK_ONLY: state_d = ST_CLK_ON;
            default:     state_d = ST_CLK_OFF;
          endcase
        end
      end
      ST_RST_ON: begin
        tmr_load = 1'b1;
        tmr_val  = PRE_LD;
        state_d  = ST_WAIT_PRE;
      end
      ST_WAIT_PRE: begin
        if (timer_zero) state_d = ST_CLK_ON;
      end
      ST_CLK_ON: begin
        if (full_q) begin
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LD;
          state_d  = ST_WAIT_SETTLE;
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_WAIT_SETTLE: begin
        if (timer_zero) state_d = ST_RST_OFF;
      end
      ST_RST_OFF: state_d = ST_DONE;
      ST_CLK_OFF: state_d = ST_DONE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      full_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) full_q <= (op == OP_FULL);
    end
  end

  assign state = state_q;

endmodule

// File: rtl/clkseq_outdec.sv
module clkseq_outdec
  import clkseq_pkg::*;
(
  input  seq_state_t state,
  output logic       gate_on,
  output logic       gate_off,
  output logic       rst_assert,
  output logic       rst_release,
  output logic       busy,
  output logic       ready,
  output logic       done
);

  assign rst_assert  = (state == ST_RST_ON);
  assign gate_on     = (state == ST_CLK_ON);
  assign rst_release = (state == ST_RST_OFF);
  assign gate_off    = (state == ST_CLK_OFF);
  assign done        = (state == ST_DONE);
  assign busy        = (state != ST_IDLE);
  assign ready       = (state == ST_IDLE);

endmodule

// File: rtl/clk_rst_seq.sv
module clk_rst_seq
  import clkseq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 250_000_000,
  parameter int unsigned PRE_US    = 100,
  parameter int unsigned SETTLE_US = 10_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_enable,
  output logic req_ready,
  input  logic gate_running,
  input  logic periph_in_reset,
  input  logic has_reset_line,
  output logic gate_on,
  output logic gate_off,
  output logic rst_assert,
  output logic rst_release,
  output logic busy,
  output logic done
);

  localparam int unsigned PRE_CYC    = us_to_cycles(64'(CLK_HZ), 64'(PRE_US));
  localparam int unsigned SETTLE_CYC = us_to_cycles(64'(CLK_HZ), 64'(SETTLE_US));
  localparam int unsigned MAX_CYC    = (PRE_CYC > SETTLE_CYC) ? PRE_CYC : SETTLE_CYC;
  localparam int unsigned CNT_W      = bits_for(MAX_CYC);

  // named internal events, visible to the bound checker
  logic             accept;
  seq_op_t          op;
  seq_state_t       state;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             timer_zero;

  assign accept = req_valid && req_ready;

  clkseq_decode i_decode (
    .req_enable      (req_enable),
    .gate_running    (gate_running),
    .periph_in_reset (periph_in_reset),
    .has_reset_line  (has_reset_line),
    .op              (op)
  );

  clkseq_fsm #(
    .CNT_W      (CNT_W),
    .PRE_CYC    (PRE_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .op         (op),
    .timer_zero (timer_zero),
    .state      (state),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val)
  );

  clkseq_timer #(
    .CNT_W (CNT_W)
  ) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (timer_zero)
  );

  clkseq_outdec i_outdec (
    .state       (state),
    .gate_on     (gate_on),
    .gate_off    (gate_off),
    .rst_assert  (rst_assert),
    .rst_release (rst_release),
    .busy        (busy),
    .ready       (req_ready),
    .done        (done)
  );

endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        req_enable,
  input logic        req_ready,
  input logic        busy,
  input logic        done,
  input logic        gate_on,
  input logic        gate_off,
  input logic        rst_assert,
  input logic        rst_release,
  input logic [31:0] pre_cyc,
  input logic [31:0] settle_cyc
);

  logic [31:0] since_rast_q, since_gon_q;
  logic        armed_q, op_dis_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_rast_q <= '0;
      since_gon_q  <= '0;
      armed_q      <= 1'b0;
      op_dis_q     <= 1'b0;
    end else begin
      if (rst_assert)              since_rast_q <= 32'd1;
      else if (~&since_rast_q)     since_rast_q <= since_rast_q + 32'd1;
      if (gate_on)                 since_gon_q  <= 32'd1;
      else if (~&since_gon_q)      since_gon_q  <= since_gon_q + 32'd1;
      if (rst_assert)              armed_q <= 1'b1;
      else if (rst_release)        armed_q <= 1'b0;
      if (accept)                  op_dis_q <= !req_enable;
    end
  end

  // R3: clock ungated exactly PRE+1 cycles after the reset assert
  p_pre_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && armed_q) |-> (since_rast_q == pre_cyc + 32'd1));

  // R3: reset released exactly SETTLE+1 cycles after the ungate
  p_settle_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_release |-> (armed_q && since_gon_q == settle_cyc + 32'd1));

  // R6: a disable sequence never drives the reset line or ungates
  p_disable_no_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_dis_q) |-> (!rst_assert && !rst_release && !gate_on));

  // R8: at most one command or done per cycle
  p_single_action_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, gate_on, gate_off, rst_assert, rst_release}));

  // R8: done is a single-cycle pulse
  p_done_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: nothing is commanded while idle, and idle means ready
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (req_ready && !done && !gate_on && !gate_off && !rst_assert && !rst_release));

  // R7: an accepted request makes the block busy on the next cycle
  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R7: busy rises only after a handshake
  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(accept));

endmodule

bind clk_rst_seq clkseq_chk i_clkseq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept      (accept),
  .req_enable  (req_enable),
  .req_ready   (req_ready),
  .busy        (busy),
  .done        (done),
  .gate_on     (gate_on),
  .gate_off    (gate_off),
  .rst_assert  (rst_assert),
  .rst_release (rst_release),
  .pre_cyc     (32'(PRE_CYC)),
  .settle_cyc  (32'(SETTLE_CYC))
);

// File: tb/test_clk_rst_seq.sv
`timescale 1ns/1ps
module test_clk_rst_seq;

  // 2.5 MHz notional clock: 2 us -> 5 cycles, 4 us -> 10 cycles
  localparam int unsigned CLK_HZ    = 2_500_000;
  localparam int unsigned PRE_US    = 2;
  localparam int unsigned SETTLE_US = 4;
  localparam int PRE    = (CLK_HZ / 500_000) * PRE_US / 2;     // 5
  localparam int SETTLE = (CLK_HZ / 500_000) * SETTLE_US / 2;  // 10
  localparam int W      = PRE + SETTLE + 8;

  // kind codes: 0 no-op, 1 full sequence, 2 clock only, 3 gate off
  // entry: {enable, gate_running, in_reset, has_reset, kind[1:0]}
  localparam int NV = 11;
  localparam logic [5:0] VEC [NV] = '{
    {4'b1101, 2'd0}, {4'b1100, 2'd0}, {4'b1110, 2'd0},
    {4'b1111, 2'd1}, {4'b1001, 2'd1}, {4'b1011, 2'd1},
    {4'b1000, 2'd2}, {4'b1010, 2'd2},
    {4'b0101, 2'd3}, {4'b0011, 2'd3}, {4'b0110, 2'd3}
  };

  logic clk = 1'b0;
  logic rst_n, req_valid, req_enable, gate_running, periph_in_reset, has_reset_line;
  logic req_ready, gate_on, gate_off, rst_assert, rst_release, busy, done;
  int   checks = 0;
  int   fails  = 0;

  always #2 clk = ~clk;

  clk_rst_seq #(
    .CLK_HZ    (CLK_HZ),
    .PRE_US    (PRE_US),
    .SETTLE_US (SETTLE_US)
  ) i_clk_rst_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_enable      (req_enable),
    .req_ready       (req_ready),
    .gate_running    (gate_running),
    .periph_in_reset (periph_in_reset),
    .has_reset_line  (has_reset_line),
    .gate_on         (gate_on),
    .gate_off        (gate_off),
    .rst_assert      (rst_assert),
    .rst_release     (rst_release),
    .busy            (busy),
    .done            (done)
  );

  // observed vector: {busy, done, rst_release, gate_on, gate_off, rst_assert}
  function automatic logic [5:0] observe();
    return {busy, done, rst_release, gate_on, gate_off, rst_assert};
  endfunction

  function automatic logic [5:0] exp_vec(input int kind, input int k);
    logic [5:0] v;
    int last;
    v = '0;
    case (kind)
      0: begin last = 0; if (k == 0) v[4] = 1'b1; end
      1: begin
        last = PRE + SETTLE + 3;
        if (k == 0)                v[0] = 1'b1;
        if (k == PRE + 1)          v[2] = 1'b1;
        if (k == PRE + SETTLE + 2) v[3] = 1'b1;
        if (k == last)             v[4] = 1'b1;
      end
      2: begin last = 1; if (k == 0) v[2] = 1'b1; if (k == 1) v[4] = 1'b1; end
      default: begin last = 1; if (k == 0) v[1] = 1'b1; if (k == 1) v[4] = 1'b1; end
    endcase
    v[5] = (k <= last);
    return v;
  endfunction

  task automatic report(input string tag, input logic [5:0] act, input logic [5:0] exv, input int k);
    $display("FAIL %s cycle %0d actual=%b expected=%b", tag, k, act, exv);
  endtask

  // disturb: 0 none, 1 flip state inputs at cycle 1 (R9), 2 short request while busy (R7)
  task automatic run_seq(input logic [3:0] ins, input int kind, input string tag, input int disturb);
    int bad;
    logic [5:0] obs, ev;
    bad = 0;
    @(negedge clk);
    {req_enable, gate_running, periph_in_reset, has_reset_line} = ins;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (disturb == 1 && k == 1) begin
        gate_running = ~gate_running; periph_in_reset = ~periph_in_reset;
        has_reset_line = ~has_reset_line;
      end
      if (disturb == 2 && k == 2) begin req_valid = 1'b1; req_enable = 1'b0; end
      if (disturb == 2 && k == 3) req_valid = 1'b0;
      obs = observe();
      ev  = exp_vec(kind, k);
      if (obs !== ev) begin
        if (bad == 0) report(tag, obs, ev, k);
        bad++;
      end
      @(negedge clk);
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [5:0] hexp [6];
    logic [5:0] obs;
    int bad;
    rst_n = 1'b0; req_valid = 1'b0; req_enable = 1'b0;
    gate_running = 1'b0; periph_in_reset = 1'b0; has_reset_line = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    checks++;
    if ({req_ready, observe()} !== 7'b1_000000) begin
      fails++; $display("FAIL R1 reset state actual=%b expected=%b", {req_ready, observe()}, 7'b1_000000);
    end

    // table walk: R2 no-op, R3/R4 full, R5 clock only, R6 gate off; R8 pulse shapes
    for (int i = 0; i < NV; i++) begin
      string tag;
      case (int'(VEC[i][1:0]))
        0: tag = "R2";
        1: tag = VEC[i][4] ? "R4" : "R3";
        2: tag = "R5";
        default: tag = "R6";
      endcase
      run_seq(VEC[i][5:2], int'(VEC[i][1:0]), $sformatf("%s R8 vec%0d", tag, i), 0);
    end

    // R7: request raised and dropped while busy is ignored
    run_seq(4'b1001, 1, "R7 withdrawn request", 2);

    // R9: state inputs flipped mid-sequence do not change the sequence
    run_seq(4'b1001, 1, "R9 sampled at accept", 1);

    // R7: request held valid is taken once ready returns
    hexp[0] = 6'b100100; hexp[1] = 6'b110000; hexp[2] = 6'b000000;
    hexp[3] = 6'b100010; hexp[4] = 6'b110000; hexp[5] = 6'b000000;
    bad = 0;
    @(negedge clk);
    {req_enable, gate_running, periph_in_reset, has_reset_line} = 4'b1000;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_enable = 1'b0;
    for (int k = 0; k < 6; k++) begin
      obs = observe();
      if (obs !== hexp[k]) begin
        if (bad == 0) report("R7 held request", obs, hexp[k], k);
        bad++;
      end
      if (k == 2 && req_ready !== 1'b1) begin
        if (bad == 0) report("R7 ready return", {5'b0, req_ready}, 6'b000001, k);
        bad++;
      end
      if (k == 3) req_valid = 1'b0;
      @(negedge clk);
    end
    checks++;
    if (bad != 0) fails++;

    // R1: reset in the middle of a full sequence returns to idle
    @(negedge clk);
    {req_enable, gate_running, periph_in_reset, has_reset_line} = 4'b1001;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    bad = 0;
    for (int k = 0; k < W; k++) begin
      if ({req_ready, observe()} !== 7'b1_000000) begin
        if (bad == 0) $display("FAIL R1 mid-sequence reset cycle %0d actual=%b expected=%b",
                               k, {req_ready, observe()}, 7'b1_000000);
        bad++;
      end
      @(negedge clk);
    end
    checks++;
    if (bad != 0) fails++;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule